// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a watchdog timer with a small register window. A 32-bit counter counts upward on a slow timer tick, which the clock domain delivers as a one-cycle enable. A power-of-two prescaler can divide that tick. When the counter steps past all-ones, the block raises a one-cycle reset request and reloads the counter from its load value. Supervisory software keeps the system alive by writing the trigger register with a value that differs from the one it wrote before. Such a write copies the load value into the counter.

Writes to the control, load, trigger and start/stop registers are posted. Each write raises a per-register pending flag and takes effect on the second timer tick after the host write. Software polls the flags until they clear. The counter is started or stopped only by an ordered pair of key words written to the start/stop register. A wrong partner word cancels the half-finished pair, and the run state stays as it was.

Top module: `wdt_keyed_top`

## Requirements
- R1: After reset the counter reads 0, the applied load value is 0, all pending flags are 0, the block is stopped and `rst_req_o` is low.
- R2: Reads return the following.
  - 0x00 gives the constant `REV_ID`.
  - 0x10 bit 0 is a read/write gating enable that takes effect at once.
  - Any unmapped offset reads 0.
  - 0x28 returns the live counter, and writes to it are ignored.
- R3: The posted registers and their flag bits in the pending-status word at 0x34 are:
  - control at 0x24, flag bit 0;
  - load at 0x2C, flag bit 2;
  - trigger at 0x30, flag bit 3;
  - start/stop at 0x48, flag bit 4.

  A host write to one of them sets its flag from the next cycle. The flag clears, and the value is applied, on the second tick after the write. Reads of 0x24, 0x2C, 0x30 and 0x48 return the last host-written value, with 0x24 masked to bits 5:2. A rewrite while the flag is still set replaces the data and restarts the two-tick delay.
- R4: Applying 0x0000BBBB and then 0x0000_4444 to the start/stop register starts the counter.
- R5: Applying 0x0000AAAA and then 0x0000_5555 stops the counter, which then holds its value.
- R6: If the word applied after 0xBBBB or 0xAAAA is not that word's partner, the pair is dropped and the run state is unchanged.
- R7: When a trigger write is applied, the counter is loaded with the load value only if the written word differs from the last applied trigger word, which is 0 after reset. Applying the same word again has no effect.
- R8: When the counter steps from 0xFFFFFFFF, `rst_req_o` is high for exactly one cycle. In that same cycle the counter reads the load value.
- R9: Control bit 5 enables the prescaler and bits 4:2 hold the exponent P. With the prescaler enabled, the counter steps once every 2^P ticks, counted from the tick on which the control write was applied. With it disabled, the counter steps on every tick.
- R10: While running, the counter changes by at most one step per tick. While stopped, it changes only through a trigger reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle timer tick enable |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | AW | Register byte offset |
| wdata_i | input | CW | Write data |
| rdata_o | output | CW | Read data for `addr_i`, combinational |
| rst_req_o | output | 1 | One-cycle reset request on counter wrap |

## Verification
A corrupted key-sequence state shows up within the next few ticks as a counter that freezes or keeps running when it should not. A wrong pending-age value moves the clearing of a status bit by whole ticks, which a cycle-exact comparison of the status word exposes on the cycle it happens. An error in the prescaler or in the trigger comparison changes the counter's value within a few ticks. The bench compares the read port and the reset request against a behavioural model on every clock. It also runs targeted sequences for the key pairs, repeated trigger words, wraps and prescaler rates.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam logic [7:0] OFF_REV    = 8'h00;
    localparam logic [7:0] OFF_SYSCFG = 8'h10;
    localparam logic [7:0] OFF_CTRL   = 8'h24;
    localparam logic [7:0] OFF_COUNT  = 8'h28;
    localparam logic [7:0] OFF_LOAD   = 8'h2C;
    localparam logic [7:0] OFF_TRIG   = 8'h30;
    localparam logic [7:0] OFF_PEND   = 8'h34;
    localparam logic [7:0] OFF_KEY    = 8'h48;

    localparam logic [15:0] KEY_RUN_A  = 16'hBBBB;
    localparam logic [15:0] KEY_RUN_B  = 16'h4444;
    localparam logic [15:0] KEY_HALT_A = 16'hAAAA;
    localparam logic [15:0] KEY_HALT_B = 16'h5555;

    localparam int SLOT_CTRL = 0;
    localparam int SLOT_LOAD = 1;
    localparam int SLOT_TRIG = 2;
    localparam int SLOT_KEY  = 3;
    localparam int NUM_SLOTS = 4;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_RUN_HALF,
        SEQ_HALT_HALF
    } seq_e;

    function automatic logic [7:0] slot_off(int idx);
        case (idx)
            SLOT_CTRL: return OFF_CTRL;
            SLOT_LOAD: return OFF_LOAD;
            SLOT_TRIG: return OFF_TRIG;
            default:   return OFF_KEY;
        endcase
    endfunction

endpackage

// File: rtl/wdt_post_slot.sv
module wdt_post_slot #(
    parameter int DW  = 32,
    parameter int LAT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    output logic          pend_o,
    output logic          land_o,
    output logic [DW-1:0] data_o
);
    localparam int AGE_W = $clog2(LAT + 1);
    localparam logic [AGE_W-1:0] LAST_AGE = AGE_W'(LAT - 1);

    typedef struct packed {
        logic             pend;
        logic [AGE_W-1:0] age;
        logic [DW-1:0]    data;
    } slot_t;

    slot_t s_d, s_q;
    logic  land_d;

    always_comb begin
        s_d    = s_q;
        land_d = tick_i && s_q.pend && (s_q.age == LAST_AGE) && !wr_i;
        if (wr_i) begin
            s_d.pend = 1'b1;
            s_d.age  = '0;
            s_d.data = wdata_i;
        end else if (tick_i && s_q.pend) begin
            if (s_q.age == LAST_AGE) begin
                s_d.pend = 1'b0;
                s_d.age  = '0;
            end else begin
                s_d.age = s_q.age + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pend_o = s_q.pend;
    assign land_o = land_d;
    assign data_o = s_q.data;

    // R3: a host write always leaves the flag raised
    assert_pend_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> pend_o);

    // R3: a value lands only out of a raised flag, which then drops
    assert_land_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        land_o |=> !pend_o);

endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
    import wdt_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          land_i,
    input  logic [CW-1:0] word_i,
    output logic          run_o
);
    typedef struct packed {
        seq_e st;
        logic run;
    } seq_t;

    seq_t k_d, k_q;

    always_comb begin
        k_d = k_q;
        if (land_i) begin
            if (word_i == CW'(KEY_RUN_A)) begin
                k_d.st = SEQ_RUN_HALF;
            end else if (word_i == CW'(KEY_HALT_A)) begin
                k_d.st = SEQ_HALT_HALF;
            end else begin
                if (k_q.st == SEQ_RUN_HALF && word_i == CW'(KEY_RUN_B))
                    k_d.run = 1'b1;
                if (k_q.st == SEQ_HALT_HALF && word_i == CW'(KEY_HALT_B))
                    k_d.run = 1'b0;
                k_d.st = SEQ_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) k_q <= '{st: SEQ_IDLE, run: 1'b0};
        else        k_q <= k_d;
    end

    assign run_o = k_q.run;

    // R4: the counter starts only on the second word of the start pair
    assert_start_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_o) |-> $past(land_i && word_i == CW'(KEY_RUN_B)));

    // R5: the counter stops only on the second word of the stop pair
    assert_stop_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_o) |-> $past(land_i && word_i == CW'(KEY_HALT_B)));

    // R6: nothing changes the run state except an applied word
    assert_run_needs_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !land_i |=> $stable(run_o));

endmodule

// File: rtl/wdt_count_core.sv
module wdt_count_core #(
    parameter int CW = 32,
    parameter int EW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          run_i,
    input  logic          pre_en_i,
    input  logic [EW-1:0] pre_exp_i,
    input  logic          pre_clr_i,
    input  logic          reload_i,
    input  logic [CW-1:0] reload_val_i,
    output logic [CW-1:0] cnt_o,
    output logic          wrap_o
);
    localparam int PW = (1 << EW) - 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [PW-1:0] pcnt;
        logic          wrap;
    } core_t;

    core_t c_d, c_q;
    logic [PW-1:0] mask;
    logic          step;

    always_comb begin
        mask = ~({PW{1'b1}} << pre_exp_i);
        step = run_i && tick_i && (!pre_en_i || c_q.pcnt == mask);
        c_d      = c_q;
        c_d.wrap = 1'b0;
        if (reload_i) begin
            c_d.cnt = reload_val_i;
        end else if (step) begin
            if (&c_q.cnt) begin
                c_d.cnt  = reload_val_i;
                c_d.wrap = 1'b1;
            end else begin
                c_d.cnt = c_q.cnt + 1'b1;
            end
        end
        if (!run_i || pre_clr_i) begin
            c_d.pcnt = '0;
        end else if (tick_i && pre_en_i) begin
            c_d.pcnt = (c_q.pcnt == mask) ? '0 : c_q.pcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cnt_o  = c_q.cnt;
    assign wrap_o = c_q.wrap;

    // R10: while stopped and not reloaded the counter holds
    assert_hold_when_stopped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !reload_i) |=> $stable(cnt_o));

    // R10: without a tick the counter cannot step
    assert_no_step_without_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i) |=> $stable(cnt_o));

    // R8: a reset request follows only an all-ones count
    assert_wrap_from_max_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |-> &($past(cnt_o)));

endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top
    import wdt_pkg::*;
#(
    parameter int          CW     = 32,
    parameter int          EW     = 3,
    parameter int          LAT    = 2,
    parameter int          AW     = 8,
    parameter logic [31:0] REV_ID = 32'h0000_0031
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [CW-1:0] wdata_i,
    output logic [CW-1:0] rdata_o,
    output logic          rst_req_o
);
    localparam int            EXP_LSB   = 2;
    localparam int            EN_POS    = EXP_LSB + EW;
    localparam logic [CW-1:0] CTRL_MASK = CW'(((1 << (EW + 1)) - 1) << EXP_LSB);

    logic [NUM_SLOTS-1:0] slot_wr, slot_pend, slot_land;
    logic [CW-1:0]        slot_data [NUM_SLOTS];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign slot_wr[g] = wr_en_i && (addr_i == AW'(slot_off(g)));
        wdt_post_slot #(.DW(CW), .LAT(LAT)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (tick_i),
            .wr_i    (slot_wr[g]),
            .wdata_i (wdata_i),
            .pend_o  (slot_pend[g]),
            .land_o  (slot_land[g]),
            .data_o  (slot_data[g])
        );
    end

    typedef struct packed {
        logic          pre_en;
        logic [EW-1:0] pre_exp;
        logic [CW-1:0] load;
        logic [CW-1:0] trig;
        logic          auto_gate;
    } regs_t;

    regs_t r_d, r_q;
    logic [CW-1:0] load_eff;
    logic          trig_hit;
    logic          run;
    logic [CW-1:0] cnt;
    logic          wrap;
    logic [CW-1:0] pend_word;

    always_comb begin
        r_d      = r_q;
        load_eff = slot_land[SLOT_LOAD] ? slot_data[SLOT_LOAD] : r_q.load;
        trig_hit = slot_land[SLOT_TRIG] && (slot_data[SLOT_TRIG] != r_q.trig);
        if (slot_land[SLOT_CTRL]) begin
            r_d.pre_en  = slot_data[SLOT_CTRL][EN_POS];
            r_d.pre_exp = slot_data[SLOT_CTRL][EXP_LSB +: EW];
        end
        r_d.load = load_eff;
        if (slot_land[SLOT_TRIG]) r_d.trig = slot_data[SLOT_TRIG];
        if (wr_en_i && addr_i == AW'(OFF_SYSCFG)) r_d.auto_gate = wdata_i[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    wdt_key_seq #(.CW(CW)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .land_i (slot_land[SLOT_KEY]),
        .word_i (slot_data[SLOT_KEY]),
        .run_o  (run)
    );

    wdt_count_core #(.CW(CW), .EW(EW)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .run_i        (run),
        .pre_en_i     (r_q.pre_en),
        .pre_exp_i    (r_q.pre_exp),
        .pre_clr_i    (slot_land[SLOT_CTRL]),
        .reload_i     (trig_hit),
        .reload_val_i (load_eff),
        .cnt_o        (cnt),
        .wrap_o       (wrap)
    );

    always_comb begin
        pend_word    = '0;
        pend_word[0] = slot_pend[SLOT_CTRL];
        pend_word[2] = slot_pend[SLOT_LOAD];
        pend_word[3] = slot_pend[SLOT_TRIG];
        pend_word[4] = slot_pend[SLOT_KEY];
    end

    always_comb begin
        case (addr_i)
            AW'(OFF_REV):    rdata_o = CW'(REV_ID);
            AW'(OFF_SYSCFG): rdata_o = CW'(r_q.auto_gate);
            AW'(OFF_CTRL):   rdata_o = slot_data[SLOT_CTRL] & CTRL_MASK;
            AW'(OFF_COUNT):  rdata_o = cnt;
            AW'(OFF_LOAD):   rdata_o = slot_data[SLOT_LOAD];
            AW'(OFF_TRIG):   rdata_o = slot_data[SLOT_TRIG];
            AW'(OFF_PEND):   rdata_o = pend_word;
            AW'(OFF_KEY):    rdata_o = slot_data[SLOT_KEY];
            default:         rdata_o = '0;
        endcase
    end

    assign rst_req_o = wrap;

    // R7: an applied trigger word that differs from the last one loads the counter
    assert_trig_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_land[SLOT_TRIG] && slot_data[SLOT_TRIG] != r_q.trig) |=> cnt == r_q.load);

    // R8: the reset request leaves the counter at the applied load value
    assert_wrap_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> cnt == r_q.load);

endmodule

// File: tb/wdt_keyed_top_test.sv
module wdt_keyed_top_test;
    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h28;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rst_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    wdt_keyed_top uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rst_req_o(rst_req)
    );

    always #10 clk = ~clk;

    // ---------------- behavioural reference model ----------------
    bit [31:0] m_data [4];
    bit        m_pend [4];
    int        m_age  [4];
    bit        m_en;
    int        m_exp;
    bit [31:0] m_load, m_trig, m_cnt;
    bit        m_gate, m_run, m_wrap;
    int        m_pc;
    int        m_seq;  // 0 none, 1 start half, 2 stop half

    function automatic bit [7:0] off_of(int i);
        case (i)
            0: return 8'h24;
            1: return 8'h2C;
            2: return 8'h30;
            default: return 8'h48;
        endcase
    endfunction

    function automatic bit [31:0] m_read(bit [7:0] a);
        case (a)
            8'h00: return 32'h31;
            8'h10: return {31'b0, m_gate};
            8'h24: return m_data[0] & 32'h3C;
            8'h28: return m_cnt;
            8'h2C: return m_data[1];
            8'h30: return m_data[2];
            8'h34: return {27'b0, m_pend[3], m_pend[2], m_pend[1], 1'b0, m_pend[0]};
            8'h48: return m_data[3];
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin m_data[i] = 0; m_pend[i] = 0; m_age[i] = 0; end
            m_en = 0; m_exp = 0; m_load = 0; m_trig = 0; m_cnt = 0;
            m_gate = 0; m_run = 0; m_wrap = 0; m_pc = 0; m_seq = 0;
        end else begin
            bit wr [4];
            bit land [4];
            bit [31:0] leff;
            bit reload, wrap_n, step;
            int mask;
            for (int i = 0; i < 4; i++) begin
                wr[i]   = wr_en && addr == off_of(i);
                land[i] = tick_i && m_pend[i] && m_age[i] == LAT - 1 && !wr[i];
            end
            leff   = land[1] ? m_data[1] : m_load;
            reload = land[2] && m_data[2] != m_trig;
            mask   = (1 << m_exp) - 1;
            step   = m_run && tick_i && (!m_en || m_pc == mask);
            wrap_n = 0;
            if (reload) m_cnt = leff;
            else if (step) begin
                if (m_cnt == 32'hFFFF_FFFF) begin m_cnt = leff; wrap_n = 1; end
                else m_cnt = m_cnt + 1;
            end
            if (!m_run || land[0]) m_pc = 0;
            else if (tick_i && m_en) m_pc = (m_pc == mask) ? 0 : m_pc + 1;
            if (land[3]) begin
                if (m_data[3] == 32'hBBBB) m_seq = 1;
                else if (m_data[3] == 32'hAAAA) m_seq = 2;
                else begin
                    if (m_seq == 1 && m_data[3] == 32'h4444) m_run = 1;
                    if (m_seq == 2 && m_data[3] == 32'h5555) m_run = 0;
                    m_seq = 0;
                end
            end
            if (land[0]) begin m_en = m_data[0][5]; m_exp = int'(m_data[0][4:2]); end
            m_load = leff;
            if (land[2]) m_trig = m_data[2];
            for (int i = 0; i < 4; i++) begin
                if (wr[i]) begin m_pend[i] = 1; m_age[i] = 0; m_data[i] = wdata; end
                else if (tick_i && m_pend[i]) begin
                    if (m_age[i] == LAT - 1) begin m_pend[i] = 0; m_age[i] = 0; end
                    else m_age[i] = m_age[i] + 1;
                end
            end
            if (wr_en && addr == 8'h10) m_gate = wdata[0];
            m_wrap = wrap_n;
        end
    end

    function automatic string tag_of(bit [7:0] a);
        case (a)
            8'h34: return "R3";
            8'h28: return "R10";
            default: return "R2";
        endcase
    endfunction

    // every-cycle comparison, away from the active edge
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            checks++;
            if (rdata !== m_read(addr)) begin
                errors++;
                $display("FAIL %s cycle compare addr %h: actual %h expected %h",
                         tag_of(addr), addr, rdata, m_read(addr));
            end
            checks++;
            if (rst_req !== m_wrap) begin
                errors++;
                $display("FAIL R8 reset request: actual %0b expected %0b", rst_req, m_wrap);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    initial begin
        int tdiv = 0;
        forever begin
            @(negedge clk);
            tdiv = (tdiv + 1) % 4;
            tick_i = (tdiv == 0);
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(bit [7:0] a, bit [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; addr = 8'h28;
    endtask

    task automatic rd(bit [7:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic poll();
        logic [31:0] v;
        for (int n = 0; n < 100; n++) begin
            rd(8'h34, v);
            if (v == 0) break;
            @(negedge clk);
        end
        addr = 8'h28;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v, c0, c1;
        bit seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h28, v); chk("R1 counter", v, 0);
        rd(8'h34, v); chk("R1 pending", v, 0);
        rd(8'h2C, v); chk("R1 load", v, 0);
        chk("R1 reset request", {31'b0, rst_req}, 0);
        repeat (20) @(negedge clk);
        rd(8'h28, v); chk("R1 stopped", v, 0);

        // R2 register map
        rd(8'h00, v); chk("R2 revision", v, 32'h31);
        wr(8'h10, 32'h1);
        rd(8'h10, v); chk("R2 sysconfig", v, 1);
        rd(8'h3C, v); chk("R2 unmapped", v, 0);
        wr(8'h28, 32'h1234_5678);
        repeat (12) @(negedge clk);
        rd(8'h28, v); chk("R2 counter write ignored", v, 0);

        // R3 posted load, rewrite restarts
        wr(8'h2C, 32'h10);
        rd(8'h34, v); chk("R3 load pending set", v, 32'h4);
        wr(8'h2C, 32'hFFFF_FF00);
        rd(8'h2C, v); chk("R3 load readback", v, 32'hFFFF_FF00);
        poll();
        rd(8'h34, v); chk("R3 pending cleared", v, 0);

        // R7 trigger with a new word reloads
        wr(8'h30, 32'h1234);
        poll();
        rd(8'h28, v); chk("R7 first trigger reload", v, 32'hFFFF_FF00);

        // R4 start pair, R10 one step per tick
        wr(8'h48, 32'hBBBB); poll();
        wr(8'h48, 32'h4444); poll();
        rd(8'h28, c0);
        repeat (40) @(negedge clk);
        rd(8'h28, c1);
        chk("R4 running", {31'b0, c1 != c0}, 1);
        chk("R10 ten steps in ten ticks", c1 - c0, 10);

        // R8 wrap
        seen = 0;
        for (int n = 0; n < 3000 && !seen; n++) begin
            @(posedge clk); #3;
            if (rst_req) begin
                seen = 1;
                chk("R8 count at wrap", rdata, 32'hFFFF_FF00);
            end
        end
        chk("R8 wrap seen", {31'b0, seen}, 1);
        @(posedge clk); #3;
        chk("R8 single cycle", {31'b0, rst_req}, 0);

        // R7 same word ignored, changed word reloads
        @(negedge clk);
        repeat (40) @(negedge clk);
        wr(8'h30, 32'h1234); poll();
        rd(8'h28, v); chk("R7 same word no reload", v, m_cnt);
        chk("R7 same word count moved", {31'b0, v != 32'hFFFF_FF00}, 1);
        wr(8'h30, ~32'h1234); poll();
        rd(8'h28, v); chk("R7 changed word reload", v, 32'hFFFF_FF00);

        // R9 prescaler at exponent 2
        wr(8'h24, 32'h28); poll();
        rd(8'h24, v); chk("R9 control readback", v, 32'h28);
        rd(8'h28, c0);
        repeat (256) @(negedge clk);
        rd(8'h28, c1);
        chk("R9 sixteen steps in 64 ticks", c1 - c0, 16);

        // R6 broken stop pair leaves it running
        wr(8'h48, 32'hAAAA); poll();
        wr(8'h48, 32'h1111); poll();
        rd(8'h28, c0);
        repeat (128) @(negedge clk);
        rd(8'h28, c1);
        chk("R6 still running", {31'b0, c1 != c0}, 1);

        // R5 stop pair
        wr(8'h48, 32'hAAAA); poll();
        wr(8'h48, 32'h5555); poll();
        rd(8'h28, c0);
        repeat (100) @(negedge clk);
        rd(8'h28, c1);
        chk("R5 held after stop", c1, c0);

        // R6 broken start pair leaves it stopped
        wr(8'h48, 32'hBBBB); poll();
        wr(8'h48, 32'h5555); poll();
        rd(8'h28, c0);
        repeat (100) @(negedge clk);
        rd(8'h28, c1);
        chk("R6 still stopped", c1, c0);

        // R10 reload while stopped
        wr(8'h2C, 32'h77); poll();
        wr(8'h30, 32'h1234); poll();
        rd(8'h28, v); chk("R10 stopped reload", v, 32'h77);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule